// File: doc/BRIEF.md
# Serial ADC Frame Host

This block is the host-side master for a 12-bit successive-approximation converter that is read over a chip-select framed serial link. Each transfer is opened by pulling the select line low. The block makes the serial clock from the system clock, shifts in the 14-bit word the converter returns (two leading zeros followed by the result) and presents the 12-bit result on a valid/ready output stream, together with a flag raised when the leading bits are not zero.

A frame is started by a request handshake. The first request accepted after reset always runs as a calibration frame: 16 slow clock pulses, with the returned word thrown away. After that, each request runs either a plain read (14 fast pulses) or a read with recalibration (32 slow pulses, with the result taken from the first 14 bits). The select-to-clock setup, the clock-to-deselect hold, the minimum deselect time and both half periods are parameters counted in system-clock cycles.

Back-pressure rules: a result stays on the output, unchanged, until it is taken with `res_valid && res_ready`. While a result is waiting, `req_ready` stays low, so no new frame can start and no result is ever overwritten. The request side uses `req_valid`/`req_ready`, and `req_recal` is sampled in the cycle the request is accepted.

Top module: `adc_frame_host`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 1, `res_valid` is 0 and `req_ready` is 1.
- R2: The first accepted request after reset runs 16 SCLK pulses, each with a low phase of HALF_SLOW cycles, and produces no result on the output stream.
- R3: A request accepted with `req_recal` = 0 after calibration runs 14 SCLK pulses with low phases of HALF_FAST cycles. SDO is shifted MSB first: one bit is sampled before each SCLK falling edge (the first of them after CS falls, before pulse 1). `res_data` is captured bits 2 to 13, where bit 13 is the last bit captured.
- R4: A request accepted with `req_recal` = 1 after calibration runs 32 SCLK pulses with low phases of HALF_SLOW cycles. The result comes from the first 14 captured bits, and bits after the 14th have no effect on `res_data` or `res_err`.
- R5: `res_err` is 1 when either of the two first captured bits is 1. `res_data` still carries the following 12 bits.
- R6: At least T_SETUP cycles pass between the CS falling edge and the first SCLK falling edge.
- R7: At least T_HOLD cycles pass between the last SCLK falling edge and the CS rising edge.
- R8: Between two frames, CS stays high for at least T_IDLE cycles.
- R9: SCLK is high whenever CS is high, and makes no falling edge while CS is high.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_data` and `res_err` hold, `req_ready` is 0, and a pending request starts no frame.
- R11: `res_valid` rises only once CS is already high again for the frame that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request to run a frame |
| req_recal | input | 1 | With the request: 1 asks for read plus recalibration |
| req_ready | output | 1 | Block can accept a request this cycle |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Conversion result, straight binary |
| res_err | output | 1 | Leading bits of the frame were not zero |

## Verification
The bench plays the converter: it launches a new SDO bit half a cycle after each SCLK fall. This catches a capture that is shifted by one bit (the result would come out doubled or halved, with a wrong error flag), and a recalibration frame that keeps shifting past bit 14 (the data would fill with the trailing ones the model drives). It measures pulse counts and low-phase lengths per frame kind, so a calibration frame run fast or short, or a first frame that publishes a result, is caught. It also measures setup, hold and the CS-high gap between back-to-back requests. A stalled consumer is held for many cycles while a request waits, which exposes an overwritten result or a frame started too early.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    FK_READ  = 2'd0,
    FK_CAL   = 2'd1,
    FK_RECAL = 2'd2
  } frame_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } host_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4,
  parameter int PW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          slow,
  input  logic [PW-1:0] target,
  output logic          sclk,
  output logic          fall,
  output logic          done
);

  localparam int HMAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
  localparam int HW   = $clog2(HMAX + 1);

  logic          sclk_q, act_q, slow_q;
  logic [HW-1:0] half_q;
  logic [PW-1:0] pcnt_q, tgt_q;
  logic [HW-1:0] half_start, half_run;
  logic          phase_end, last;

  assign half_start = slow   ? HW'(HALF_SLOW - 1) : HW'(HALF_FAST - 1);
  assign half_run   = slow_q ? HW'(HALF_SLOW - 1) : HW'(HALF_FAST - 1);
  assign phase_end  = act_q && (half_q == '0);
  assign last       = (pcnt_q == tgt_q);

  // one strobe per falling edge of the serial clock, in the cycle it is driven low
  assign fall = (start && !act_q) || (phase_end && sclk_q && !last);
  assign done = phase_end && sclk_q && last;
  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      act_q  <= 1'b0;
      slow_q <= 1'b0;
      half_q <= '0;
      pcnt_q <= '0;
      tgt_q  <= '0;
    end else if (start && !act_q) begin
      act_q  <= 1'b1;
      sclk_q <= 1'b0;
      half_q <= half_start;
      pcnt_q <= PW'(1);
      tgt_q  <= target;
      slow_q <= slow;
    end else if (act_q) begin
      if (half_q != '0) begin
        half_q <= half_q - HW'(1);
      end else if (!sclk_q) begin
        sclk_q <= 1'b1;
        half_q <= half_run;
      end else if (last) begin
        act_q <= 1'b0;
      end else begin
        sclk_q <= 1'b0;
        half_q <= half_run;
        pcnt_q <= pcnt_q + PW'(1);
      end
    end
  end

  // R9: the clock rests high whenever no burst is running
  a_r9_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> sclk_q);

  // R3: a burst never runs past the pulse count it was started with
  a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (pcnt_q <= tgt_q) && (pcnt_q != '0));

  // R3: the burst ends with the clock high
  a_r3_end_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sclk_q && !act_q);

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
  parameter int LEAD_BITS = 2,
  parameter int RES_BITS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                take,
  input  logic                sdo,
  output logic [RES_BITS-1:0] data,
  output logic                lead_err
);

  localparam int FRAME_BITS = LEAD_BITS + RES_BITS;
  localparam int CW         = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         cnt_q;
  logic                  full;

  assign full = (cnt_q == CW'(FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take && !full) begin
      sh_q  <= {sh_q[FRAME_BITS-2:0], sdo};
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign data     = sh_q[RES_BITS-1:0];
  assign lead_err = |sh_q[FRAME_BITS-1:RES_BITS];

  // R4: once a full word is in, later clock pulses leave it untouched
  a_r4_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> $stable(sh_q));

endmodule

// File: rtl/adc_res_stage.sv
module adc_res_stage #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RES_BITS-1:0] ld_data,
  input  logic                ld_err,
  input  logic                res_ready,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= ld_data;
      res_err   <= ld_err;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R10: a stalled result keeps its value
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data) && $stable(res_err));

  // R10: nothing is written over a result not yet taken
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !res_valid);

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_host_pkg::*;
#(
  parameter int T_SETUP      = 2,
  parameter int T_HOLD       = 2,
  parameter int T_IDLE       = 12,
  parameter int PULSES_READ  = 14,
  parameter int PULSES_CAL   = 16,
  parameter int PULSES_RECAL = 32,
  parameter int PW           = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_recal,
  input  logic          res_pend,
  input  logic          gen_done,
  output logic          req_ready,
  output logic          cs_n,
  output logic          gen_start,
  output logic          gen_slow,
  output logic [PW-1:0] gen_target,
  output logic          cap_clear,
  output logic          publish
);

  localparam int TM1 = (T_SETUP > T_HOLD) ? T_SETUP : T_HOLD;
  localparam int TMX = (TM1 > T_IDLE) ? TM1 : T_IDLE;
  localparam int TW  = $clog2(TMX + 1);

  host_state_e state_q;
  frame_kind_e kind_q, next_kind;
  logic [TW-1:0] cnt_q;
  logic          cs_n_q, cal_done_q, accept, cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE) && !res_pend;
  assign accept    = req_valid && req_ready;
  assign cap_clear = accept;
  assign cs_n      = cs_n_q;
  assign gen_start = (state_q == ST_SETUP) && cnt_zero;
  assign gen_slow  = (kind_q != FK_READ);
  assign publish   = (state_q == ST_HOLD) && cnt_zero && (kind_q != FK_CAL);

  always_comb begin
    if (!cal_done_q)    next_kind = FK_CAL;
    else if (req_recal) next_kind = FK_RECAL;
    else                next_kind = FK_READ;
  end

  always_comb begin
    case (kind_q)
      FK_CAL:   gen_target = PW'(PULSES_CAL);
      FK_RECAL: gen_target = PW'(PULSES_RECAL);
      default:  gen_target = PW'(PULSES_READ);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= FK_READ;
      cnt_q      <= '0;
      cs_n_q     <= 1'b1;
      cal_done_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          cs_n_q  <= 1'b0;
          cnt_q   <= TW'(T_SETUP - 1);
          kind_q  <= next_kind;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (!cnt_zero) cnt_q <= cnt_q - TW'(1);
          else           state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (gen_done) begin
          cnt_q   <= TW'(T_HOLD - 1);
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - TW'(1);
          end else begin
            cs_n_q  <= 1'b1;
            cnt_q   <= TW'(T_IDLE - 1);
            state_q <= ST_GAP;
            if (kind_q == FK_CAL) cal_done_q <= 1'b1;
          end
        end
        ST_GAP: begin
          if (!cnt_zero) cnt_q <= cnt_q - TW'(1);
          else           state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the calibration frame comes first, and only once
  a_r2_cal_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cal_done_q) |=> (kind_q == FK_CAL));

  // R9: the select line stays low through the whole burst
  a_r9_cs_low_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> !cs_n_q);

  // R11: a result is loaded in the cycle the select line goes high
  a_r11_publish_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> cs_n_q);

endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
  import adc_host_pkg::*;
#(
  parameter int HALF_FAST    = 2,
  parameter int HALF_SLOW    = 4,
  parameter int T_SETUP      = 2,
  parameter int T_HOLD       = 2,
  parameter int T_IDLE       = 12,
  parameter int PULSES_READ  = 14,
  parameter int PULSES_CAL   = 16,
  parameter int PULSES_RECAL = 32,
  parameter int LEAD_BITS    = 2,
  parameter int RES_BITS     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_recal,
  output logic                req_ready,
  output logic                cs_n,
  output logic                sclk,
  input  logic                sdo,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_err
);

  localparam int PMAX = (PULSES_RECAL > PULSES_CAL) ? PULSES_RECAL : PULSES_CAL;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int GW   = $clog2(T_IDLE + 1);

  logic          gen_start, gen_slow, gen_fall, gen_done;
  logic [PW-1:0] gen_target;
  logic          cap_clear, publish, cap_err;
  logic [RES_BITS-1:0] cap_data;

  adc_frame_fsm #(
    .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_IDLE(T_IDLE),
    .PULSES_READ(PULSES_READ), .PULSES_CAL(PULSES_CAL),
    .PULSES_RECAL(PULSES_RECAL), .PW(PW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_recal(req_recal),
    .res_pend(res_valid), .gen_done(gen_done), .req_ready(req_ready),
    .cs_n(cs_n), .gen_start(gen_start), .gen_slow(gen_slow),
    .gen_target(gen_target), .cap_clear(cap_clear), .publish(publish)
  );

  adc_sclk_gen #(
    .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW), .PW(PW)
  ) u_clk (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .slow(gen_slow),
    .target(gen_target), .sclk(sclk), .fall(gen_fall), .done(gen_done)
  );

  adc_rx_capture #(
    .LEAD_BITS(LEAD_BITS), .RES_BITS(RES_BITS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(cap_clear), .take(gen_fall),
    .sdo(sdo), .data(cap_data), .lead_err(cap_err)
  );

  adc_res_stage #(
    .RES_BITS(RES_BITS)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .load(publish), .ld_data(cap_data),
    .ld_err(cap_err), .res_ready(res_ready), .res_valid(res_valid),
    .res_data(res_data), .res_err(res_err)
  );

  // checker state: cycles CS has been high, and whether a frame has ended yet
  logic [GW-1:0] hi_cnt_q;
  logic          had_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q    <= '0;
      had_frame_q <= 1'b0;
    end else begin
      if (!cs_n)                         hi_cnt_q <= '0;
      else if (hi_cnt_q != GW'(T_IDLE))  hi_cnt_q <= hi_cnt_q + GW'(1);
      if (!cs_n) had_frame_q <= 1'b1;
    end
  end

  a_r9_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r10_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r11_result_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> cs_n);

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && had_frame_q) |-> (hi_cnt_q >= GW'(T_IDLE)));

endmodule

// File: tb/tb_adc_frame_host.sv
module tb_adc_frame_host;

  localparam int HF = 2, HS = 4, TS = 2, TH = 2, TI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_recal = 1'b0, res_ready = 1'b0;
  logic sdo = 1'b1;
  logic req_ready, cs_n, sclk, res_valid, res_err;
  logic [11:0] res_data;

  always #4 clk = ~clk;

  adc_frame_host #(.HALF_FAST(HF), .HALF_SLOW(HS), .T_SETUP(TS), .T_HOLD(TH),
                   .T_IDLE(TI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_recal(req_recal),
    .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_err(res_err)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model and frame monitor, both evaluated on the falling system edge
  logic [13:0] word = '0;
  logic        trail = 1'b0;
  int cyc = 0, idx = 0, pulses = 0, lowcnt = 0, lowmin = 0, lowmax = 0;
  int t_fall = 0, t_rise = 0, t_first = 0, t_last = 0, gap = 0;
  int fr_pulses = 0, fr_setup = 0, fr_hold = 0, fr_lowmin = 0, fr_lowmax = 0;
  int frames = 0, idle_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      t_fall = cyc; gap = cyc - t_rise; pulses = 0;
      lowmin = 1000; lowmax = 0; idx = 0; sdo = word[13];
    end
    if (!cs_n && prev_sclk && !sclk) begin
      if (pulses == 0) t_first = cyc;
      pulses++; t_last = cyc; lowcnt = 0; idx++;
      sdo = (idx < 14) ? word[13-idx] : trail;
    end
    if (!sclk) lowcnt++;
    if (!prev_sclk && sclk && !cs_n) begin
      if (lowcnt < lowmin) lowmin = lowcnt;
      if (lowcnt > lowmax) lowmax = lowcnt;
    end
    if (!prev_cs && cs_n) begin
      t_rise = cyc; fr_pulses = pulses; fr_setup = t_first - t_fall;
      fr_hold = cyc - t_last; fr_lowmin = lowmin; fr_lowmax = lowmax;
      frames++; sdo = 1'b1;
    end
    if (cs_n && !sclk) idle_bad++;
    prev_cs = cs_n; prev_sclk = sclk;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit recal);
    @(negedge clk);
    req_valid = 1'b1; req_recal = recal;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_frame(input int start);
    while (frames == start) @(negedge clk);
  endtask

  task automatic frame_shape(input string req, input int npulse, input int half);
    check(fr_pulses == npulse, req, "pulse count", fr_pulses, npulse);
    check(fr_lowmin == half && fr_lowmax == half, req, "low phase", fr_lowmax, half);
    check(fr_setup >= TS, "R6", "setup cycles", fr_setup, TS);
    check(fr_hold >= TH, "R7", "hold cycles", fr_hold, TH);
  endtask

  task automatic take_result(input string req, input int exp_d, input bit exp_e);
    while (!res_valid) @(negedge clk);
    check(cs_n == 1'b1, "R11", "cs_n at result", cs_n, 1);
    check(res_data == exp_d, req, "res_data", res_data, exp_d);
    check(res_err == exp_e, req, "res_err", res_err, exp_e);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    check(sclk == 1'b1, "R1", "sclk", sclk, 1);
    check(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
  endtask

  task automatic t_cal;
    int f0 = frames;
    bit seen = 0;
    word = 14'h3FFF; trail = 1'b1;
    issue(1'b1);
    wait_frame(f0);
    frame_shape("R2", 16, HS);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (res_valid) seen = 1;
    end
    check(!seen, "R2", "result after cal frame", seen, 0);
  endtask

  task automatic t_read(input logic [11:0] d);
    int f0 = frames;
    word = {2'b00, d}; trail = 1'b1;
    issue(1'b0);
    wait_frame(f0);
    frame_shape("R3", 14, HF);
    take_result("R3", d, 1'b0);
  endtask

  task automatic t_recal;
    int f0 = frames;
    word = {2'b00, 12'h3C6}; trail = 1'b1;
    issue(1'b1);
    wait_frame(f0);
    frame_shape("R4", 32, HS);
    take_result("R4", 12'h3C6, 1'b0);
  endtask

  task automatic t_err;
    int f0 = frames;
    word = {2'b10, 12'h5A1}; trail = 1'b0;
    issue(1'b0);
    wait_frame(f0);
    take_result("R5", 12'h5A1, 1'b1);
    f0 = frames;
    word = {2'b01, 12'h00F};
    issue(1'b0);
    wait_frame(f0);
    take_result("R5", 12'h00F, 1'b1);
  endtask

  task automatic t_backpressure;
    int f0 = frames;
    bit bad = 0;
    word = {2'b00, 12'h9E3}; trail = 1'b0;
    issue(1'b0);
    wait_frame(f0);
    while (!res_valid) @(negedge clk);
    word = {2'b00, 12'h124};
    req_valid = 1'b1; req_recal = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!res_valid || res_data != 12'h9E3 || req_ready || !cs_n) bad = 1;
    end
    check(!bad, "R10", "stall kept result and blocked frame", bad, 0);
    check(frames == f0 + 1, "R10", "frames during stall", frames, f0 + 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_frame(f0 + 1);
    take_result("R10", 12'h124, 1'b0);
  endtask

  task automatic t_back_to_back;
    int f0 = frames;
    word = {2'b00, 12'h777}; trail = 1'b0;
    res_ready = 1'b1;
    issue(1'b0);
    issue(1'b0);
    wait_frame(f0 + 1);
    check(gap >= TI, "R8", "cs high gap", gap, TI);
    res_ready = 1'b0;
    repeat (TI + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cal();
    t_read(12'hA5C);
    t_read(12'h000);
    t_read(12'hFFF);
    t_read(12'h801);
    t_recal();
    t_err();
    t_backpressure();
    t_back_to_back();
    check(idle_bad == 0, "R9", "sclk low while cs high", idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule